// File: doc/BRIEF.md
# Selectable Packet Line Scrambler and Descrambler

This block balances the ones and zeros of a 64-bit serial packet stream. The transmit half turns each packet word into the line word. The receive half restores the original packet from the line word. Bit 63 of a word is the first bit on the line. The top 8 bits form the header, the next 48 bits the data, and the low 8 bits the check field.

Four modes are offered. The first passes the packet through. The second is a long self-synchronizing scrambler on x^58 + x^39 + 1. The third is a short self-synchronizing scrambler on x^7 + x^6 + 1. The fourth is a deterministic inversion balancer that flips fixed bit positions in every packet.

A scope code limits the effect to the whole packet, to header plus data, or to data only. Bits outside the scope leave unchanged. Each 64-bit word is processed in a single cycle. The result equals 64 steps of the serial, first-bit-first implementation.

Top module: `pkt_scr_link`

## Requirements
- R1: Mode code 0 (none): tx_out_word equals the tx_in_word accepted one cycle earlier, and tx_out_vld equals tx_in_vld delayed by one cycle. Every mode has this same one-cycle latency, on both halves.
- R2: Mode code 1 (long): the word is handled bit by bit from bit 63 down to bit 0. Each in-scope line bit is the input bit XOR the line bits sent 39 and 58 bits earlier. Line bits sent before reset count as 0.
- R3: Mode code 2 (short): the same rule as R2, with the line bits sent 6 and 7 bits earlier.
- R4: Mode code 3 (invert): every packet, including all-ones and all-zeros packets, has its in-scope bits at even word indices (the 2nd, 4th, ... bits sent) inverted. No other bits change.
- R5: Scope code 0 covers bits [63:0]. Code 1 covers bits [63:8]. Code 2 covers bits [55:8]. Code 3 acts as code 0. Out-of-scope bits pass unchanged in every mode.
- R6: The scrambler history advances by all 64 line bits of each valid word, including out-of-scope bits. It does not advance on cycles without a valid word.
- R7: The receive half, given the line word with the same mode and scope, produces on rx_out_word the original packet one cycle later, with rx_out_vld set.
- R8: The descrambler is self-synchronizing. Once its history holds the last 58 line bits, its output is correct whatever its earlier history was.
- R9: rx_lock is 1 when rx_mode is 0 or 3. In mode 1 or 2 it is 1 once at least 58 (mode 1) or 7 (mode 2) line bits have been received since reset.
- R10: After reset both valid outputs are 0, both output words are 0, and both histories are all zeros.
- R11: On a cycle without a valid input, the output word of that half holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_vld | input | 1 | Packet word valid, transmit half |
| tx_in_word | input | 64 | Packet word, bit 63 sent first |
| tx_mode | input | 2 | Transmit mode: 0 none, 1 long, 2 short, 3 invert |
| tx_scope | input | 2 | Transmit scope code |
| tx_out_vld | output | 1 | Line word valid |
| tx_out_word | output | 64 | Line word |
| rx_in_vld | input | 1 | Line word valid, receive half |
| rx_in_word | input | 64 | Received line word |
| rx_mode | input | 2 | Receive mode, same coding as tx_mode |
| rx_scope | input | 2 | Receive scope code |
| rx_out_vld | output | 1 | Restored packet valid |
| rx_out_word | output | 64 | Restored packet word |
| rx_lock | output | 1 | Descrambler history filled for the current mode |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- exact pass-through in mode none;
- the fixed inversion pattern for full-scope invert packets;
- the untouched header and check fields under the data-only scope;
- the holding of output words on idle cycles;
- lock after any received word.

Some behaviour depends on history and needs the bench's scenarios. The bench compares the polynomial outputs against a serial bit-by-bit model, with scope changes and idle gaps in between. It checks the round trip through the receive half. It shows self-synchronization recovering after a line word is withheld from the receiver. It shows the lock flag before and after the first received word.

// File: rtl/pkt_scr_pkg.sv
package pkt_scr_pkg;

    typedef enum logic [1:0] {
        SCR_NONE   = 2'd0,
        SCR_LONG   = 2'd1,
        SCR_SHORT  = 2'd2,
        SCR_INVERT = 2'd3
    } scr_mode_e;

    typedef enum logic [1:0] {
        SCOPE_FULL     = 2'd0,
        SCOPE_HDR_DATA = 2'd1,
        SCOPE_DATA     = 2'd2,
        SCOPE_FULL_ALT = 2'd3
    } scr_scope_e;

endpackage

// File: rtl/pkt_scope_mask.sv
module pkt_scope_mask #(
    parameter int WORD_W = 64,
    parameter int HDR_W  = 8,
    parameter int ECC_W  = 8
) (
    input  logic [1:0]        scope,
    output logic [WORD_W-1:0] mask
);
    import pkt_scr_pkg::*;

    scr_scope_e scope_e;
    assign scope_e = scr_scope_e'(scope);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        localparam bit IN_HDR = (i >= WORD_W - HDR_W);
        localparam bit IN_ECC = (i < ECC_W);
        always_comb begin
            case (scope_e)
                SCOPE_HDR_DATA: mask[i] = !IN_ECC;
                SCOPE_DATA:     mask[i] = !(IN_ECC || IN_HDR);
                default:        mask[i] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pkt_scr_core.sv
module pkt_scr_core #(
    parameter int WORD_W     = 64,
    parameter int LONG_A     = 58,
    parameter int LONG_B     = 39,
    parameter int SHORT_A    = 7,
    parameter int SHORT_B    = 6,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] scope_mask,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word
);
    import pkt_scr_pkg::*;

    localparam int HIST_W = LONG_A;

    function automatic logic [WORD_W-1:0] alt_mask_f();
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = 1'(((WORD_W - 1 - i) % 2) == 1);
        end
        return r;
    endfunction

    localparam logic [WORD_W-1:0] ALT_MASK = alt_mask_f();

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic [HIST_W-1:0] hist;
    } core_st_t;

    core_st_t st_d, st_q;

    scr_mode_e mode_e;
    logic      is_long, is_short, is_inv;
    assign mode_e   = scr_mode_e'(mode);
    assign is_long  = (mode_e == SCR_LONG);
    assign is_short = (mode_e == SCR_SHORT);
    assign is_inv   = (mode_e == SCR_INVERT);

    logic [HIST_W-1:0] h;
    logic [WORD_W-1:0] w;
    logic              ib, ob, fb, lb;

    always_comb begin
        h  = st_q.hist;
        w  = '0;
        ib = 1'b0;
        ob = 1'b0;
        fb = 1'b0;
        lb = 1'b0;
        for (int k = 0; k < WORD_W; k++) begin
            ib = in_word[WORD_W-1-k];
            fb = is_long ? (h[LONG_B-1] ^ h[LONG_A-1])
                         : (h[SHORT_B-1] ^ h[SHORT_A-1]);
            ob = ib;
            if ((is_long || is_short) && scope_mask[WORD_W-1-k]) begin
                ob = ib ^ fb;
            end
            if (is_inv && scope_mask[WORD_W-1-k] && ALT_MASK[WORD_W-1-k]) begin
                ob = ~ib;
            end
            lb = DESCRAMBLE ? ib : ob;
            h  = {h[HIST_W-2:0], lb};
            w[WORD_W-1-k] = ob;
        end

        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.word = w;
            st_d.hist = h;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_word = st_q.word;

endmodule

// File: rtl/pkt_lock_tracker.sv
module pkt_lock_tracker #(
    parameter int WORD_W  = 64,
    parameter int LONG_A  = 58,
    parameter int SHORT_A = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic [1:0] mode,
    output logic       lock
);
    import pkt_scr_pkg::*;

    localparam int CNT_W    = $clog2(LONG_A + 1);
    localparam int STEP_INT = (WORD_W < LONG_A) ? WORD_W : LONG_A;
    localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_A);
    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_A);
    localparam logic [CNT_W-1:0] STEP_CNT  = CNT_W'(STEP_INT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {1'b0, STEP_CNT};
        if (in_vld) begin
            st_d.cnt = (sum > {1'b0, LONG_CNT}) ? LONG_CNT : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (scr_mode_e'(mode))
            SCR_LONG:  lock = (st_q.cnt >= LONG_CNT);
            SCR_SHORT: lock = (st_q.cnt >= SHORT_CNT);
            default:   lock = 1'b1;
        endcase
    end

endmodule

// File: rtl/pkt_scr_link.sv
module pkt_scr_link #(
    parameter int WORD_W  = 64,
    parameter int HDR_W   = 8,
    parameter int ECC_W   = 8,
    parameter int LONG_A  = 58,
    parameter int LONG_B  = 39,
    parameter int SHORT_A = 7,
    parameter int SHORT_B = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_in_vld,
    input  logic [WORD_W-1:0] tx_in_word,
    input  logic [1:0]        tx_mode,
    input  logic [1:0]        tx_scope,
    output logic              tx_out_vld,
    output logic [WORD_W-1:0] tx_out_word,
    input  logic              rx_in_vld,
    input  logic [WORD_W-1:0] rx_in_word,
    input  logic [1:0]        rx_mode,
    input  logic [1:0]        rx_scope,
    output logic              rx_out_vld,
    output logic [WORD_W-1:0] rx_out_word,
    output logic              rx_lock
);

    logic [WORD_W-1:0] tx_mask, rx_mask;

    pkt_scope_mask #(.WORD_W(WORD_W), .HDR_W(HDR_W), .ECC_W(ECC_W)) i_tx_mask (
        .scope (tx_scope),
        .mask  (tx_mask)
    );

    pkt_scope_mask #(.WORD_W(WORD_W), .HDR_W(HDR_W), .ECC_W(ECC_W)) i_rx_mask (
        .scope (rx_scope),
        .mask  (rx_mask)
    );

    pkt_scr_core #(
        .WORD_W(WORD_W), .LONG_A(LONG_A), .LONG_B(LONG_B),
        .SHORT_A(SHORT_A), .SHORT_B(SHORT_B), .DESCRAMBLE(1'b0)
    ) i_tx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (tx_in_vld),
        .in_word    (tx_in_word),
        .mode       (tx_mode),
        .scope_mask (tx_mask),
        .out_vld    (tx_out_vld),
        .out_word   (tx_out_word)
    );

    pkt_scr_core #(
        .WORD_W(WORD_W), .LONG_A(LONG_A), .LONG_B(LONG_B),
        .SHORT_A(SHORT_A), .SHORT_B(SHORT_B), .DESCRAMBLE(1'b1)
    ) i_rx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (rx_in_vld),
        .in_word    (rx_in_word),
        .mode       (rx_mode),
        .scope_mask (rx_mask),
        .out_vld    (rx_out_vld),
        .out_word   (rx_out_word)
    );

    pkt_lock_tracker #(.WORD_W(WORD_W), .LONG_A(LONG_A), .SHORT_A(SHORT_A)) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (rx_in_vld),
        .mode   (rx_mode),
        .lock   (rx_lock)
    );

endmodule

// File: rtl/pkt_scr_link_chk.sv
module pkt_scr_link_chk #(
    parameter int WORD_W = 64,
    parameter int HDR_W  = 8,
    parameter int ECC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_in_vld,
    input logic [WORD_W-1:0] tx_in_word,
    input logic [1:0]        tx_mode,
    input logic [1:0]        tx_scope,
    input logic              tx_out_vld,
    input logic [WORD_W-1:0] tx_out_word,
    input logic              rx_in_vld,
    input logic [WORD_W-1:0] rx_out_word,
    input logic              rx_lock
);
    localparam logic [WORD_W-1:0] ALT = {(WORD_W/2){2'b01}};

    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 0) |-> (tx_out_vld == $past(tx_in_vld))); // R1

    AST_NONE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && $past(tx_in_vld) && ($past(tx_mode) == 2'd0))
        |-> (tx_out_word == $past(tx_in_word))); // R1

    AST_INVERT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && $past(tx_in_vld) && ($past(tx_mode) == 2'd3)
         && (($past(tx_scope) == 2'd0) || ($past(tx_scope) == 2'd3)))
        |-> (tx_out_word == ($past(tx_in_word) ^ ALT))); // R4

    AST_SCOPE_EDGES_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && $past(tx_in_vld) && ($past(tx_scope) == 2'd2))
        |-> ((tx_out_word[WORD_W-1 -: HDR_W] == $past(tx_in_word[WORD_W-1 -: HDR_W]))
          && (tx_out_word[ECC_W-1:0] == $past(tx_in_word[ECC_W-1:0])))); // R5

    AST_TX_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && !$past(tx_in_vld)) |-> $stable(tx_out_word)); // R11

    AST_RX_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && !$past(rx_in_vld)) |-> $stable(rx_out_word)); // R11

    AST_LOCK_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q != 0) && $past(rx_in_vld)) |-> rx_lock); // R9

endmodule

bind pkt_scr_link pkt_scr_link_chk #(.WORD_W(WORD_W), .HDR_W(HDR_W), .ECC_W(ECC_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_in_vld   (tx_in_vld),
    .tx_in_word  (tx_in_word),
    .tx_mode     (tx_mode),
    .tx_scope    (tx_scope),
    .tx_out_vld  (tx_out_vld),
    .tx_out_word (tx_out_word),
    .rx_in_vld   (rx_in_vld),
    .rx_out_word (rx_out_word),
    .rx_lock     (rx_lock)
);

// File: tb/test_pkt_scr_link.sv
module test_pkt_scr_link;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_in_vld = 1'b0;
    logic [63:0] tx_in_word = '0;
    logic [1:0]  tx_mode = '0;
    logic [1:0]  tx_scope = '0;
    logic        tx_out_vld;
    logic [63:0] tx_out_word;
    logic        rx_in_vld = 1'b0;
    logic [63:0] rx_in_word = '0;
    logic [1:0]  rx_mode = '0;
    logic [1:0]  rx_scope = '0;
    logic        rx_out_vld;
    logic [63:0] rx_out_word;
    logic        rx_lock;

    always #(CLK_P/2) clk = ~clk;

    pkt_scr_link i_pkt_scr_link (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [57:0] tx_h = '0;
    logic [57:0] rx_h = '0;

    typedef struct packed {
        logic [1:0]  m;
        logic [1:0]  s;
        logic [63:0] w;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{2'd1, 2'd0, 64'h0123_4567_89AB_CDEF},
        '{2'd1, 2'd0, 64'h0000_0000_0000_0000},
        '{2'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'd1, 2'd2, 64'hDEAD_BEEF_CAFE_F00D},
        '{2'd2, 2'd0, 64'h0000_0000_0000_0000},
        '{2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'd2, 2'd1, 64'h1357_9BDF_0246_8ACE},
        '{2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'd3, 2'd0, 64'h0000_0000_0000_0000},
        '{2'd3, 2'd2, 64'hA5A5_A5A5_A5A5_A5A5},
        '{2'd0, 2'd0, 64'h0F0F_0F0F_0F0F_0F0F},
        '{2'd0, 2'd3, 64'h1234_5678_9ABC_DEF0},
        '{2'd1, 2'd3, 64'h8000_0000_0000_0001},
        '{2'd3, 2'd1, 64'h3C3C_3C3C_3C3C_3C3C}
    };

    // Serial reference: bit 63 first, history index 0 is the newest line bit.
    task automatic ref_run(input logic [63:0] w, input logic [1:0] m, input logic [1:0] s,
                           input bit desc, inout logic [57:0] h, output logic [63:0] o);
        for (int k = 0; k < 64; k++) begin
            bit in_sc;
            logic ib, ob, fb;
            in_sc = (s == 2'd1) ? (k < 56) : (s == 2'd2) ? (k >= 8 && k < 56) : 1'b1;
            ib = w[63-k];
            fb = (m == 2'd1) ? (h[38] ^ h[57]) : (h[5] ^ h[6]);
            ob = ib;
            if ((m == 2'd1 || m == 2'd2) && in_sc) ob = ib ^ fb;
            if (m == 2'd3 && in_sc && (k % 2 == 1)) ob = ~ib;
            h = {h[56:0], desc ? ib : ob};
            o[63-k] = ob;
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tx_req(input logic [1:0] m);
        case (m)
            2'd0: return "R1 none";
            2'd1: return "R2 long";
            2'd2: return "R3 short";
            default: return "R4 invert";
        endcase
    endfunction

    task automatic send_tx(input logic [63:0] w, input logic [1:0] m, input logic [1:0] s,
                           output logic [63:0] line, input string req);
        logic [63:0] exp;
        tx_in_vld = 1'b1; tx_in_word = w; tx_mode = m; tx_scope = s;
        ref_run(w, m, s, 1'b0, tx_h, exp);
        @(posedge clk); @(negedge clk);
        tx_in_vld = 1'b0;
        check(req, tx_out_word, exp);
        check("R1 tx valid", {63'd0, tx_out_vld}, 64'd1);
        line = tx_out_word;
    endtask

    task automatic send_rx(input logic [63:0] line, input logic [1:0] m, input logic [1:0] s,
                           output logic [63:0] exp);
        rx_in_vld = 1'b1; rx_in_word = line; rx_mode = m; rx_scope = s;
        ref_run(line, m, s, 1'b1, rx_h, exp);
        @(posedge clk); @(negedge clk);
        rx_in_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_in_vld = 1'b0; rx_in_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tx_h = '0; rx_h = '0;
    endtask

    initial begin
        logic [63:0] line, exp, line_a, line_b, line_c, held;
        do_reset();

        // R10: reset state
        check("R10 tx valid", {63'd0, tx_out_vld}, 64'd0);
        check("R10 tx word", tx_out_word, 64'd0);
        check("R10 rx valid", {63'd0, rx_out_vld}, 64'd0);
        check("R10 rx word", rx_out_word, 64'd0);

        // R9: lock before any received word
        rx_mode = 2'd2; #1;
        check("R9 short unlocked", {63'd0, rx_lock}, 64'd0);
        rx_mode = 2'd1; #1;
        check("R9 long unlocked", {63'd0, rx_lock}, 64'd0);
        rx_mode = 2'd3; #1;
        check("R9 invert locked", {63'd0, rx_lock}, 64'd1);

        // Vector table: transmit, then loop the line word back through the receiver
        for (int v = 0; v < 14; v++) begin
            send_tx(VECS[v].w, VECS[v].m, VECS[v].s, line, tx_req(VECS[v].m));
            if (VECS[v].s == 2'd2) begin
                check("R5 header untouched", {56'd0, line[63:56]}, {56'd0, VECS[v].w[63:56]});
                check("R5 check field untouched", {56'd0, line[7:0]}, {56'd0, VECS[v].w[7:0]});
            end else if (VECS[v].s == 2'd1) begin
                check("R5 check field untouched", {56'd0, line[7:0]}, {56'd0, VECS[v].w[7:0]});
            end
            send_rx(line, VECS[v].m, VECS[v].s, exp);
            check("R7 round trip", rx_out_word, VECS[v].w);
            check("R7 rx valid", {63'd0, rx_out_vld}, 64'd1);
            check("R11 tx hold", tx_out_word, line);
            check("R1 tx valid low", {63'd0, tx_out_vld}, 64'd0);
            check("R9 lock", {63'd0, rx_lock}, 64'd1);
        end

        // R6: idle cycles do not advance history; scope change still advances by 64
        repeat (3) @(negedge clk);
        held = rx_out_word;
        check("R11 rx hold", rx_out_word, held);
        send_tx(64'hF0F0_1234_5678_0F0F, 2'd1, 2'd2, line, "R6 history after idle");
        send_tx(64'h0000_0000_0000_0000, 2'd1, 2'd0, line, "R6 history through scope");
        send_tx(64'h0000_0000_0000_0000, 2'd2, 2'd1, line, "R6 short after long");

        // R8: withhold one line word from the receiver, then it must resynchronize
        send_tx(64'h1111_2222_3333_4444, 2'd1, 2'd0, line_a, "R2 long prefix");
        send_tx(64'h5555_6666_7777_8888, 2'd1, 2'd0, line_b, "R2 long middle");
        send_rx(line_b, 2'd1, 2'd0, exp);
        check("R8 first word per history", rx_out_word, exp);
        send_tx(64'h9999_AAAA_BBBB_CCCC, 2'd1, 2'd0, line_c, "R2 long tail");
        send_rx(line_c, 2'd1, 2'd0, exp);
        check("R8 resynchronized", rx_out_word, 64'h9999_AAAA_BBBB_CCCC);

        // R9 after a fresh reset: one received word raises lock
        do_reset();
        rx_mode = 2'd2; #1;
        check("R9 short unlocked after reset", {63'd0, rx_lock}, 64'd0);
        rx_mode = 2'd0; #1;
        check("R9 none locked", {63'd0, rx_lock}, 64'd1);
        send_rx(64'hCAFE_0000_0000_BABE, 2'd2, 2'd0, exp);
        check("R9 short lock after word", {63'd0, rx_lock}, 64'd1);
        check("R3 short descramble from zero history", rx_out_word, exp);
        rx_mode = 2'd1; #1;
        check("R9 long lock after word", {63'd0, rx_lock}, 64'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule